// File: doc/BRIEF.md
# Single-Line Merging Write Buffer with Timeout Flush

The block sits between a simple request port and an external memory path. It gathers writes that land inside one aligned line of four 32-bit words, combines them byte by byte under their byte enables, and hands the whole line to memory through a flush port with a valid/ready handshake. Each flush carries the line address, the 128-bit line image and a 16-bit byte-enable mask.

A line leaves the buffer for one of three reasons. The first is that a down counter, reloaded from a 16-bit software-written timeout register on every accepted write, expires. The second is that a write arrives for another line. The third is that a read arrives for the buffered line. A timeout value of zero switches off the expiry path, so data then waits until a conflicting request pushes it out. While a flush is pending the request port is stalled. After the handshake the buffer is empty, and the stalled request is served against that empty buffer.

Top module: `line_merge_wbuf`

## Requirements
- R1: After reset, `flush_valid` is 0, `cfg_rdata` is 0 and `req_ready` is 1.
- R2: A value written with `cfg_wr` high is returned on `cfg_rdata` from the next cycle on, all 16 bits intact.
- R3: Writes to the buffered line, or to an empty buffer, are accepted in the cycle they are presented. The word index is address bits [3:2]; address bits [1:0] are ignored. On flush, word w sits in `flush_data[32w+31:32w]` and its byte enables in `flush_be[4w+3:4w]`. A later write to a byte replaces the earlier value. Bytes never written read as 0. `flush_addr` is address bits [31:4].
- R4: With a nonzero timeout T, `flush_valid` rises on the T-th rising clock edge after the edge that accepted the most recent write. Every accepted write restarts this count from T.
- R5: With a timeout value of 0, buffered data is never flushed by time alone.
- R6: A write to a line other than the buffered one is stalled (`req_ready` low). The buffered line is offered on the next edge. The write is accepted in the cycle after the flush handshake, and the following flush holds only its bytes.
- R7: A read whose line matches the buffered line holds `req_ready` low until the line has been flushed, then is acknowledged. A read to another line, or a read to an empty buffer, is acknowledged at once.
- R8: While `flush_valid` is high and `flush_ready` is low, the flush address, data and enables stay unchanged and `req_ready` stays low. The edge that completes the handshake empties the buffer.
- R9: No flush is ever offered with an all-zero byte-enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the timeout register |
| cfg_wdata | input | 16 | New timeout value |
| cfg_rdata | output | 16 | Current timeout value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables of the write |
| req_ready | output | 1 | Request accepted or acknowledged this cycle |
| flush_valid | output | 1 | Line offered to memory |
| flush_ready | input | 1 | Memory takes the line |
| flush_addr | output | 28 | Line address |
| flush_data | output | 128 | Line image |
| flush_be | output | 16 | Byte enables of the line |

## Verification
The hardest case to reach from the ports is a write accepted on the very cycle the counter would otherwise expire. A close second is a conflicting request that meets a flush held back by a low `flush_ready`. Directed sequences set small timeout values and time the writes against the count. They also hold `flush_ready` low across a conflicting write. A long pseudo-random phase then mixes writes and reads over two neighbouring lines, toggles `flush_ready` at random and rewrites the timeout with values from 0 to 7. A behavioural byte-array model checks every cycle, so it judges each of these collisions.

// File: rtl/wbm_pkg.sv
// Shared constants and types for the merging write buffer.
// Assumes: consumers size their own ports from these defaults.
package wbm_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_WORD_W = 32;
    localparam int DEF_WORDS  = 4;
    localparam int DEF_TMO_W  = 16;

    // Controller phase: gathering writes, or offering the line to memory.
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_DRAIN   = 1'b1
    } drain_state_e;
endpackage

// File: rtl/wbm_line_store.sv
// Line storage: holds one aligned line as byte lanes with per-lane valid
// bits plus the line tag. Merges accepted writes lane by lane.
// Assumes: WORDS is a power of two >= 2, WORD_W a multiple of 8, and
// wr_en and clear are never high together.
module wbm_line_store #(
    parameter int ADDR_W = wbm_pkg::DEF_ADDR_W,
    parameter int WORD_W = wbm_pkg::DEF_WORD_W,
    parameter int WORDS  = wbm_pkg::DEF_WORDS,
    localparam int BPW   = WORD_W / 8,
    localparam int LB    = WORDS * BPW,
    localparam int OFS_W = $clog2(LB),
    localparam int IDX_W = $clog2(WORDS),
    localparam int BSEL  = $clog2(BPW),
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    clear,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [BPW-1:0]          wr_be,
    output logic [TAG_W-1:0]        line_tag,
    output logic [WORDS*WORD_W-1:0] line_data,
    output logic [LB-1:0]           line_be,
    output logic                    nonempty
);
    logic [IDX_W-1:0]        wr_idx;
    logic [WORDS*WORD_W-1:0] data_nxt;
    logic [LB-1:0]           be_nxt;

    assign wr_idx = wr_addr[BSEL +: IDX_W];

    // Per-lane next state: merge the lane when its word and enable are selected.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            localparam int L = w * BPW + b;
            logic lane_hit;
            assign lane_hit = wr_en && (wr_idx == IDX_W'(w)) && wr_be[b];
            assign data_nxt[L*8 +: 8] = clear    ? 8'h00 :
                                        lane_hit ? wr_data[b*8 +: 8] :
                                                   line_data[L*8 +: 8];
            assign be_nxt[L] = clear ? 1'b0 : (lane_hit | line_be[L]);
        end
    end

    // Lane registers: data and valid bits of the whole line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_data <= '0;
            line_be   <= '0;
        end else begin
            line_data <= data_nxt;
            line_be   <= be_nxt;
        end
    end

    // Tag register: follows the line of every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_tag <= '0;
        else if (wr_en)
            line_tag <= wr_addr[ADDR_W-1:OFS_W];
    end

    assign nonempty = |line_be;
endmodule

// File: rtl/wbm_timeout.sv
// Timeout unit: software-visible timeout register and the buffer's down
// counter. The counter is loaded on each accepted write, counts down once
// per cycle while not held, and reports expiry on the step from 1 to 0.
// A loaded value of zero leaves the counter disarmed.
// Assumes: clear and load are never high together.
module wbm_timeout #(
    parameter int TMO_W = wbm_pkg::DEF_TMO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [TMO_W-1:0] cfg_wdata,
    output logic [TMO_W-1:0] cfg_value,
    input  logic             load,
    input  logic             clear,
    input  logic             hold,
    output logic             expire
);
    logic [TMO_W-1:0] tmo_q;
    logic [TMO_W-1:0] cnt_q;
    logic             armed_q;

    // Timeout register: written by software, read back unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_q <= '0;
        else if (cfg_wr)
            tmo_q <= cfg_wdata;
    end

    // Down counter: reload on write, zero on flush, else count while free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (clear) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= tmo_q;
            armed_q <= (tmo_q != '0);
        end else if (!hold && (cnt_q != '0)) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Expiry: the last count step, unless a reload or a hold wins this cycle.
    always_comb begin
        expire = armed_q && (cnt_q == TMO_W'(1)) && !load && !hold && !clear;
    end

    assign cfg_value = tmo_q;
endmodule

// File: rtl/wbm_drain_ctrl.sv
// Drain controller: decides when the line is offered to memory and which
// requests may proceed. A conflict (write to another line, read to this
// line) or an expiry starts a flush; requests stall until it completes.
// Assumes: req_hit is meaningful only while nonempty is high.
module wbm_drain_ctrl
    import wbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_hit,
    input  logic expire,
    input  logic flush_ready,
    output logic req_ready,
    output logic flush_valid,
    output logic accept_wr,
    output logic flush_done
);
    drain_state_e state_q;
    drain_state_e state_d;
    logic         conflict;
    logic         draining;
    logic         start;

    // Request decode: conflict, stall, write acceptance, handshake.
    always_comb begin
        draining   = (state_q == ST_DRAIN);
        conflict   = req_valid && nonempty && (req_write ? !req_hit : req_hit);
        req_ready  = !draining && !conflict;
        accept_wr  = req_valid && req_write && req_ready;
        flush_done = draining && flush_ready;
        start      = !draining && nonempty && (conflict || expire);
    end

    // Next phase: leave drain on handshake, enter it on conflict or expiry.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_COLLECT: if (start)       state_d = ST_DRAIN;
            ST_DRAIN:   if (flush_ready) state_d = ST_COLLECT;
            default:                     state_d = ST_COLLECT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_COLLECT;
        else
            state_q <= state_d;
    end

    assign flush_valid = draining;
endmodule

// File: rtl/line_merge_wbuf.sv
// Top level of the single-line merging write buffer. Ties together the
// line store, the timeout unit and the drain controller, and drives the
// flush port straight from the stored line.
// Assumes: one request per cycle, held stable until req_ready is seen.
module line_merge_wbuf #(
    parameter int ADDR_W = wbm_pkg::DEF_ADDR_W,
    parameter int WORD_W = wbm_pkg::DEF_WORD_W,
    parameter int WORDS  = wbm_pkg::DEF_WORDS,
    parameter int TMO_W  = wbm_pkg::DEF_TMO_W,
    localparam int BPW   = WORD_W / 8,
    localparam int LB    = WORDS * BPW,
    localparam int OFS_W = $clog2(LB),
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [TMO_W-1:0]        cfg_wdata,
    output logic [TMO_W-1:0]        cfg_rdata,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_W-1:0]       req_wdata,
    input  logic [BPW-1:0]          req_be,
    output logic                    req_ready,
    output logic                    flush_valid,
    input  logic                    flush_ready,
    output logic [TAG_W-1:0]        flush_addr,
    output logic [WORDS*WORD_W-1:0] flush_data,
    output logic [LB-1:0]           flush_be
);
    logic             accept_wr;
    logic             flush_done;
    logic             nonempty;
    logic             expire;
    logic             req_hit;
    logic [TAG_W-1:0] line_tag;

    // Line compare: does the request address fall in the buffered line.
    always_comb begin
        req_hit = (req_addr[ADDR_W-1:OFS_W] == line_tag);
    end

    wbm_line_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept_wr),
        .clear     (flush_done),
        .wr_addr   (req_addr),
        .wr_data   (req_wdata),
        .wr_be     (req_be),
        .line_tag  (line_tag),
        .line_data (flush_data),
        .line_be   (flush_be),
        .nonempty  (nonempty)
    );

    wbm_timeout #(
        .TMO_W (TMO_W)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_value (cfg_rdata),
        .load      (accept_wr),
        .clear     (flush_done),
        .hold      (flush_valid),
        .expire    (expire)
    );

    wbm_drain_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonempty    (nonempty),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_hit     (req_hit),
        .expire      (expire),
        .flush_ready (flush_ready),
        .req_ready   (req_ready),
        .flush_valid (flush_valid),
        .accept_wr   (accept_wr),
        .flush_done  (flush_done)
    );

    assign flush_addr = line_tag;
endmodule

// File: rtl/wbm_checker.sv
// Property checker for line_merge_wbuf, attached by bind. Watches only
// the top-level ports.
module wbm_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int TMO_W  = 16,
    localparam int BPW   = WORD_W / 8,
    localparam int LB    = WORDS * BPW,
    localparam int OFS_W = $clog2(LB),
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_wr,
    input logic [TMO_W-1:0]        cfg_wdata,
    input logic [TMO_W-1:0]        cfg_rdata,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    req_ready,
    input logic                    flush_valid,
    input logic                    flush_ready,
    input logic [TAG_W-1:0]        flush_addr,
    input logic [WORDS*WORD_W-1:0] flush_data,
    input logic [LB-1:0]           flush_be
);
    logic same_line;
    assign same_line = (req_addr[ADDR_W-1:OFS_W] == flush_addr);

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == $past(cfg_wdata));

    a_r4_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ready) |=> !flush_valid);

    a_r6_other_line_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !flush_valid && flush_be != '0 && !same_line)
        |-> !req_ready);

    a_r7_read_hit_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !flush_valid && flush_be != '0 && same_line)
        |-> !req_ready ##1 flush_valid);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_ready) |=>
        (flush_valid && $stable(flush_data) && $stable(flush_be) && $stable(flush_addr)));

    a_r8_stall_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !req_ready);

    a_r8_handshake_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_ready) |=> (!flush_valid && flush_be == '0));

    a_r9_never_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> flush_be != '0);
endmodule

bind line_merge_wbuf wbm_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .TMO_W  (TMO_W)
) u_wbm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .flush_valid (flush_valid),
    .flush_ready (flush_ready),
    .flush_addr  (flush_addr),
    .flush_data  (flush_data),
    .flush_be    (flush_be)
);

// File: tb/test_line_merge_wbuf.sv
`timescale 1ns/1ps
// Bench for line_merge_wbuf: directed scenarios plus a random phase, with a
// behavioural byte-array model compared against the ports every cycle.
module test_line_merge_wbuf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [15:0]  cfg_wdata = '0;
    logic [15:0]  cfg_rdata;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [3:0]   req_be = '0;
    logic         req_ready;
    logic         flush_valid;
    logic         flush_ready = 1'b1;
    logic [27:0]  flush_addr;
    logic [127:0] flush_data;
    logic [15:0]  flush_be;

    int  vectors = 0;
    int  misses  = 0;
    bit  run     = 1'b0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    line_merge_wbuf i_line_merge_wbuf (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .flush_valid(flush_valid), .flush_ready(flush_ready),
        .flush_addr(flush_addr), .flush_data(flush_data), .flush_be(flush_be)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_b [16];
    bit          m_v [16];
    logic [27:0] m_tag;
    logic [15:0] m_tmo;
    int          m_cnt;
    bit          m_armed;
    bit          m_fv;

    function automatic bit m_ne();
        for (int i = 0; i < 16; i++) if (m_v[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_ready();
        bit hit, conf;
        hit  = m_ne() && (req_addr[31:4] == m_tag);
        conf = req_valid && m_ne() && (req_write ? !hit : hit);
        return !m_fv && !conf;
    endfunction

    function automatic logic [127:0] m_data();
        logic [127:0] d = '0;
        for (int i = 0; i < 16; i++) d[i*8 +: 8] = m_v[i] ? m_b[i] : 8'h00;
        return d;
    endfunction

    function automatic logic [15:0] m_be();
        logic [15:0] e = '0;
        for (int i = 0; i < 16; i++) e[i] = m_v[i];
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin m_b[i] = 8'h00; m_v[i] = 1'b0; end
            m_tag = '0; m_tmo = '0; m_cnt = 0; m_armed = 1'b0; m_fv = 1'b0;
        end else begin
            bit ne, rdy, hit, conf;
            logic [15:0] new_tmo;
            ne   = m_ne();
            rdy  = m_ready();
            hit  = ne && (req_addr[31:4] == m_tag);
            conf = req_valid && ne && (req_write ? !hit : hit);
            new_tmo = cfg_wr ? cfg_wdata : m_tmo;
            if (m_fv) begin
                if (flush_ready) begin
                    for (int i = 0; i < 16; i++) begin m_b[i] = 8'h00; m_v[i] = 1'b0; end
                    m_fv = 1'b0; m_cnt = 0; m_armed = 1'b0;
                end
            end else if (conf) begin
                m_fv = 1'b1;
            end else if (req_valid && req_write && rdy) begin
                for (int b = 0; b < 4; b++)
                    if (req_be[b]) begin
                        m_b[req_addr[3:2]*4 + b] = req_wdata[b*8 +: 8];
                        m_v[req_addr[3:2]*4 + b] = 1'b1;
                    end
                m_tag   = req_addr[31:4];
                m_cnt   = m_tmo;
                m_armed = (m_tmo != 0);
            end else if (ne && m_armed && m_cnt == 1) begin
                m_fv = 1'b1; m_cnt = 0;
            end else if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
            end
            m_tmo = new_tmo;
        end
    end

    task automatic cmp(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #5;
        if (run && rst_n && !done) begin
            cmp(req_ready === m_ready(), "R6 R7 req_ready", 128'(req_ready), 128'(m_ready()));
            cmp(flush_valid === m_fv, "R4 R5 flush_valid", 128'(flush_valid), 128'(m_fv));
            cmp(cfg_rdata === m_tmo, "R2 cfg_rdata", 128'(cfg_rdata), 128'(m_tmo));
            if (m_fv) begin
                cmp(flush_addr === m_tag, "R3 flush_addr", 128'(flush_addr), 128'(m_tag));
                cmp(flush_data === m_data(), "R3 flush_data", flush_data, m_data());
                cmp(flush_be === m_be(), "R9 flush_be", 128'(flush_be), 128'(m_be()));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_tmo(input logic [15:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        #6;
        while (!req_ready) begin @(negedge clk); #6; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- directed and random sequences ----------------
    initial begin
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
        #6;
        cmp(flush_valid === 1'b0 && req_ready === 1'b1 && cfg_rdata === 16'h0,
            "R1 reset state", {flush_valid, req_ready, cfg_rdata}, {2'b01, 16'h0});

        // R2: readback of a full 16-bit value, then timeout disabled.
        set_tmo(16'hA5C3);
        #6;
        cmp(cfg_rdata === 16'hA5C3, "R2 readback", 128'(cfg_rdata), 128'h A5C3);
        set_tmo(16'h0000);

        // R3 merge and overwrite; R5 no timeout with zero.
        put(32'h0000_0100, 32'h1122_3344, 4'b0011);
        put(32'h0000_0101, 32'hAABB_CCDD, 4'b0110);
        put(32'h0000_0108, 32'h5566_7788, 4'b1000);
        seen = 1'b0;
        repeat (60) begin @(negedge clk); #6; if (flush_valid) seen = 1'b1; end
        cmp(!seen, "R5 zero timeout holds data", 128'(seen), 128'h0);

        // R7 read hit forces flush; R3 contents checked.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_010C;
        #6;
        cmp(req_ready === 1'b0, "R7 read hit stalls", 128'(req_ready), 128'h0);
        @(negedge clk); #6;
        cmp(flush_valid === 1'b1, "R7 read hit flush", 128'(flush_valid), 128'h1);
        cmp(flush_data === {32'h0, 32'h5500_0000, 32'h0, 32'h00BB_CC44},
            "R3 merged data", flush_data, {32'h0, 32'h5500_0000, 32'h0, 32'h00BB_CC44});
        cmp(flush_be === 16'h0807, "R3 merged enables", 128'(flush_be), 128'h0807);
        cmp(flush_addr === 28'h10, "R3 line address", 128'(flush_addr), 128'h10);
        @(negedge clk); #6;
        cmp(req_ready === 1'b1, "R7 read acked after flush", 128'(req_ready), 128'h1);
        @(negedge clk); req_addr = 32'h0000_0500; #6;
        cmp(req_ready === 1'b1, "R7 read empty buffer", 128'(req_ready), 128'h1);
        @(negedge clk); req_valid = 1'b0;

        // R4: timeout of 5 cycles.
        set_tmo(16'd5);
        put(32'h0000_0040, 32'hDEAD_BEEF, 4'b1111);
        n = 0;
        do begin @(negedge clk); #6; n++; end while (!flush_valid && n < 40);
        cmp(n - 1 == 5, "R4 timeout count", 128'(n - 1), 128'd5);
        idle(2);

        // R4 reload: second write restarts the count of 8.
        set_tmo(16'd8);
        put(32'h0000_0040, 32'h0000_0001, 4'b0001);
        idle(4);
        put(32'h0000_0044, 32'h0000_0002, 4'b0001);
        n = 0;
        do begin @(negedge clk); #6; n++; end while (!flush_valid && n < 40);
        cmp(n - 1 == 8, "R4 restart on write", 128'(n - 1), 128'd8);
        idle(2);

        // R7 read miss acknowledged at once while data is held.
        set_tmo(16'd0);
        put(32'h0000_0200, 32'h0102_0304, 4'b1111);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0300; #6;
        cmp(req_ready === 1'b1 && flush_valid === 1'b0, "R7 read miss acked",
            {req_ready, flush_valid}, 2'b10);
        @(negedge clk); req_valid = 1'b0;

        // R6 and R8: conflicting write against a held-back flush.
        flush_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0304;
        req_wdata = 32'hCAFE_F00D; req_be = 4'b1100; #6;
        cmp(req_ready === 1'b0, "R6 other line stalls", 128'(req_ready), 128'h0);
        repeat (4) begin
            @(negedge clk); #6;
            cmp(flush_valid === 1'b1 && req_ready === 1'b0 && flush_addr === 28'h20 &&
                flush_be === 16'h000F, "R8 held flush",
                {flush_valid, req_ready, flush_be}, {2'b10, 16'h000F});
        end
        flush_ready = 1'b1;
        @(negedge clk); #6;
        cmp(req_ready === 1'b1 && flush_valid === 1'b0, "R6 write after handshake",
            {req_ready, flush_valid}, 2'b10);
        @(posedge clk); #1; req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0300;
        @(negedge clk); #6;
        cmp(flush_be === 16'h00C0 && flush_addr === 28'h30 &&
            flush_data[63:32] === 32'hCAFE_0000, "R6 only new bytes",
            {flush_be, flush_data[63:32]}, {16'h00C0, 32'hCAFE_0000});
        @(negedge clk); @(negedge clk); req_valid = 1'b0;

        // Random phase: two lines, random enables, reads, back-pressure.
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            cfg_wr      = ($urandom % 40) == 0;
            cfg_wdata   = 16'($urandom % 8);
            req_valid   = ($urandom % 3) != 0;
            req_write   = ($urandom % 4) != 0;
            req_addr    = {27'h0, 1'($urandom), 4'($urandom)};
            req_wdata   = $urandom;
            req_be      = 4'($urandom);
            flush_ready = ($urandom % 3) != 0;
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b0; flush_ready = 1'b1;
        idle(12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule